// File: doc/BRIEF.md
# Breakpoint Acknowledge Bus Cycle Controller

This block stands between a processor core's instruction pipeline and its external bus, and runs the special read cycle that acknowledges a breakpoint. A request can come from either of two sources. One is a breakpoint instruction, which supplies a 3-bit breakpoint number taken from the low bits of its opcode. The other is a level-sensitive hardware breakpoint pin. The controller drives a CPU-space word read whose address carries both the breakpoint number and a flag for a hardware source. It then watches how the bus ends the cycle and reports one of four outcomes to the core:

- a replacement opcode to execute,
- continue with the next instruction,
- an illegal-instruction exception,
- a hardware-breakpoint exception.

The outcome depends on both the source and the termination. For a software breakpoint, a normal acknowledge returns the opcode that replaces the breakpoint instruction, and a bus error means no opcode exists. For a hardware breakpoint, a normal acknowledge discards the bus data, and a bus error asks for breakpoint exception processing. A 16-bit port returns the opcode in one transfer. An 8-bit port returns it in two transfers on the upper byte lane, high byte first.

The pin request is held in a pending latch until it is served. A pipeline flush clears this latch. The pin may therefore be held asserted until the acknowledge cycle appears on the bus.

Top module: `bkpt_ack_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bus_cyc`, `busy` and `res_valid` are 0, and `bus_fc` and `bus_addr` are all zeros.
- R2: A software request accepted on a clock edge starts a read (`bus_cyc`=1, `bus_rd`=1) in the following cycle. During that read, `bus_fc`=3'b111, `bus_addr[19:16]`=4'b0000, `bus_addr[4:2]` equals the requested number, and bits 1 and 0 are 0.
- R3: A hardware request produces the same read, except that `bus_addr[4:2]`=3'b111 and `bus_addr[1]`=1.
- R4: A software breakpoint on a 16-bit port (`port8`=0) that ends with `bus_ack` gives a one-cycle `res_valid` with `res_kind`=0 (replace) and `res_opcode` = `bus_data[15:0]`.
- R5: A software breakpoint on an 8-bit port (`port8`=1) runs two transfers. The first acknowledge does not end the cycle. `res_opcode` is {first `bus_data[15:8]`, second `bus_data[15:8]`}, and `bus_data[7:0]` is ignored.
- R6: A software breakpoint ended by `bus_err` on any transfer gives `res_kind`=2 (illegal instruction). When `bus_err` and `bus_ack` are high together, the error wins.
- R7: A hardware breakpoint ended by `bus_ack` gives `res_kind`=1 (continue) with `res_opcode`=0, whatever the data, after a single transfer even on an 8-bit port.
- R8: A hardware breakpoint ended by `bus_err` gives `res_kind`=3 (breakpoint exception).
- R9: A `hw_bkpt` level seen on a clock edge is held pending until it is served. A `flush` clears the pending request, so no cycle starts unless the pin is still high after the flush.
- R10: When a software request and a pending hardware request meet while the controller is idle, the software breakpoint is served first. The hardware request stays pending and is served afterwards.
- R11: While a cycle is in progress (`busy`=1), new software requests are ignored, and the address stays stable until the cycle ends.
- R12: With `res_kind` not replace, `res_opcode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Breakpoint instruction request, sampled when idle |
| sw_num | input | 3 | Breakpoint number (low three opcode bits) |
| hw_bkpt | input | 1 | Hardware breakpoint pin, level |
| flush | input | 1 | Pipeline flush, discards a pending pin request |
| port8 | input | 1 | 1 = 8-bit port, 0 = 16-bit port |
| bus_ack | input | 1 | Normal transfer acknowledge |
| bus_err | input | 1 | Bus error termination |
| bus_data | input | 16 | Read data; 8-bit ports use bits 15..8 |
| bus_cyc | output | 1 | Acknowledge read in progress |
| bus_rd | output | 1 | Read strobe |
| bus_fc | output | 3 | Function code, 3'b111 during the cycle |
| bus_addr | output | 20 | CPU-space address |
| busy | output | 1 | Controller cannot accept a request |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 0 replace, 1 continue, 2 illegal, 3 breakpoint exception |
| res_opcode | output | 16 | Replacement opcode, zero otherwise |

## Verification
A software request sampled on an edge puts the address on the bus one cycle later. A pin level needs two edges: one to latch it as pending and one to launch the cycle. The result strobe rises one cycle after the edge that sees the final termination and falls the cycle after that. The bench drives inputs on falling edges and samples on the next falling edge after each counted rising edge. Where the pin delay is not fixed, it polls with a small bound.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int NUM_W  = 3;
  localparam int BYTE_W = DATA_W / 2;
  localparam int FC_W   = 3;

  localparam logic [FC_W-1:0] FC_CPU_SPACE = 3'b111;
  localparam logic [3:0]      CPU_TYPE_ACK = 4'b0000;
  localparam logic [NUM_W-1:0] HW_NUM      = '1;

  typedef enum logic [1:0] {
    RES_REPLACE  = 2'd0,
    RES_CONTINUE = 2'd1,
    RES_ILLEGAL  = 2'd2,
    RES_BKPT_EXC = 2'd3
  } res_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_XFER1 = 2'd1,
    SQ_XFER2 = 2'd2
  } seq_state_e;

  // CPU-space acknowledge address: type nibble high, number on 4..2, source flag on 1
  function automatic logic [ADDR_W-1:0] ack_addr(input logic [NUM_W-1:0] num,
                                                 input logic hw);
    logic [ADDR_W-1:0] a;
    a        = '0;
    a[19:16] = CPU_TYPE_ACK;
    a[4:2]   = num;
    a[1]     = hw;
    return a;
  endfunction

  function automatic res_kind_e outcome(input logic hw, input logic err);
    if (hw) return err ? RES_BKPT_EXC : RES_CONTINUE;
    return err ? RES_ILLEGAL : RES_REPLACE;
  endfunction
endpackage

// File: rtl/bkpt_req_arb.sv
module bkpt_req_arb
  import bkpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req,
  input  logic [NUM_W-1:0] sw_num,
  input  logic             hw_pin,
  input  logic             flush,
  input  logic             seq_idle,
  output logic             launch_sw,
  output logic             launch_hw,
  output logic [NUM_W-1:0] launch_num,
  output logic             hw_pend
);
  logic hw_pend_q;

  // software instruction request outranks the pending pin request
  assign launch_sw  = seq_idle && sw_req;
  assign launch_hw  = seq_idle && !sw_req && hw_pend_q && !flush;
  assign launch_num = launch_sw ? sw_num : HW_NUM;
  assign hw_pend    = hw_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_pend_q <= 1'b0;
    end else if (flush || launch_hw) begin
      hw_pend_q <= 1'b0;
    end else if (hw_pin) begin
      hw_pend_q <= 1'b1;
    end
  end

  // R10
  pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_sw && hw_pend_q && !flush) |=> hw_pend_q);

  // R9
  flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hw_pend_q);
endmodule

// File: rtl/bkpt_bus_seq.sv
module bkpt_bus_seq
  import bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_sw,
  input  logic              launch_hw,
  input  logic [NUM_W-1:0]  launch_num,
  input  logic              port8,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              bus_cyc,
  output logic              bus_rd,
  output logic [FC_W-1:0]   bus_fc,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              seq_idle,
  output logic              cur_hw,
  output logic              term_err,
  output logic              take_word,
  output logic              take_hi,
  output logic              take_lo,
  output logic              finish
);
  seq_state_e       st_q, st_d;
  logic             hw_q;
  logic             p8_q;
  logic [NUM_W-1:0] num_q;
  logic             term_ack;
  logic             two_byte;

  assign bus_cyc  = (st_q != SQ_IDLE);
  assign seq_idle = (st_q == SQ_IDLE);
  assign bus_rd   = bus_cyc;
  assign bus_fc   = bus_cyc ? FC_CPU_SPACE : '0;
  assign bus_addr = bus_cyc ? ack_addr(num_q, hw_q) : '0;
  assign cur_hw   = hw_q;

  // error outranks acknowledge
  assign term_err  = bus_cyc && bus_err;
  assign term_ack  = bus_cyc && bus_ack && !bus_err;
  assign two_byte  = !hw_q && p8_q;
  assign take_word = term_ack && (st_q == SQ_XFER1) && !hw_q && !p8_q;
  assign take_hi   = term_ack && (st_q == SQ_XFER1) && two_byte;
  assign take_lo   = term_ack && (st_q == SQ_XFER2);
  assign finish    = term_err || (term_ack && !take_hi);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (launch_sw || launch_hw) st_d = SQ_XFER1;
      SQ_XFER1: if (take_hi) st_d = SQ_XFER2;
                else if (finish) st_d = SQ_IDLE;
      SQ_XFER2: if (finish) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      hw_q  <= 1'b0;
      p8_q  <= 1'b0;
      num_q <= '0;
    end else begin
      st_q <= st_d;
      if (seq_idle && (launch_sw || launch_hw)) begin
        hw_q  <= launch_hw;
        p8_q  <= port8;
        num_q <= launch_num;
      end
    end
  end

  // R2
  sw_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_sw |=> (bus_cyc && bus_addr[4:2] == $past(launch_num) && !bus_addr[1]
                   && !bus_addr[0] && bus_addr[19:16] == 4'b0000 && bus_fc == 3'b111));

  // R3
  hw_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_hw |=> (bus_cyc && bus_addr[4:1] == 4'b1111));

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ack && !bus_err) |=> (bus_cyc && $stable(bus_addr)));

  // R7
  hw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && hw_q && bus_ack) |=> !bus_cyc);
endmodule

// File: rtl/bkpt_result.sv
module bkpt_result
  import bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              finish,
  input  logic              cur_hw,
  input  logic              term_err,
  input  logic              take_word,
  input  logic              take_hi,
  input  logic              take_lo,
  input  logic [DATA_W-1:0] bus_data,
  output logic              res_valid,
  output res_kind_e         res_kind,
  output logic [DATA_W-1:0] res_opcode
);
  logic [BYTE_W-1:0] hi_q;
  logic [DATA_W-1:0] op_d;

  always_comb begin
    op_d = '0;
    if (take_word)    op_d = bus_data;
    else if (take_lo) op_d = {hi_q, bus_data[DATA_W-1:BYTE_W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q       <= '0;
      res_valid  <= 1'b0;
      res_kind   <= RES_REPLACE;
      res_opcode <= '0;
    end else begin
      if (take_hi) hi_q <= bus_data[DATA_W-1:BYTE_W];
      res_valid <= finish;
      if (finish) begin
        res_kind   <= outcome(cur_hw, term_err);
        res_opcode <= term_err ? '0 : op_d;
      end
    end
  end

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R12
  zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind != RES_REPLACE) |-> res_opcode == '0);

  // R8
  hw_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_err && cur_hw) |=> (res_valid && res_kind == RES_BKPT_EXC));

  // R6
  sw_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_err && !cur_hw) |=> (res_valid && res_kind == RES_ILLEGAL));
endmodule

// File: rtl/bkpt_ack_ctrl.sv
module bkpt_ack_ctrl
  import bkpt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_req,
  input  logic [2:0]          sw_num,
  input  logic                hw_bkpt,
  input  logic                flush,
  input  logic                port8,
  input  logic                bus_ack,
  input  logic                bus_err,
  input  logic [15:0]         bus_data,
  output logic                bus_cyc,
  output logic                bus_rd,
  output logic [2:0]          bus_fc,
  output logic [19:0]         bus_addr,
  output logic                busy,
  output logic                res_valid,
  output logic [1:0]          res_kind,
  output logic [15:0]         res_opcode
);
  logic             launch_sw, launch_hw, hw_pend, seq_idle;
  logic [NUM_W-1:0] launch_num;
  logic             cur_hw, term_err, take_word, take_hi, take_lo, finish;
  res_kind_e        kind_e;

  bkpt_req_arb u_arb (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_num(sw_num),
    .hw_pin(hw_bkpt), .flush(flush), .seq_idle(seq_idle),
    .launch_sw(launch_sw), .launch_hw(launch_hw), .launch_num(launch_num),
    .hw_pend(hw_pend)
  );

  bkpt_bus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch_sw(launch_sw), .launch_hw(launch_hw),
    .launch_num(launch_num), .port8(port8), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_cyc(bus_cyc), .bus_rd(bus_rd), .bus_fc(bus_fc), .bus_addr(bus_addr),
    .seq_idle(seq_idle), .cur_hw(cur_hw), .term_err(term_err),
    .take_word(take_word), .take_hi(take_hi), .take_lo(take_lo), .finish(finish)
  );

  bkpt_result u_res (
    .clk(clk), .rst_n(rst_n), .finish(finish), .cur_hw(cur_hw),
    .term_err(term_err), .take_word(take_word), .take_hi(take_hi),
    .take_lo(take_lo), .bus_data(bus_data), .res_valid(res_valid),
    .res_kind(kind_e), .res_opcode(res_opcode)
  );

  assign busy     = !seq_idle;
  assign res_kind = kind_e;

  // R9
  pend_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_pend && seq_idle && !sw_req && !flush) |=> (bus_cyc && bus_addr[1]));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(bus_addr));
endmodule

// File: tb/tb_bkpt_ack_ctrl.sv
module tb_bkpt_ack_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_req = 1'b0;
  logic [2:0]  sw_num = '0;
  logic        hw_bkpt = 1'b0;
  logic        flush = 1'b0;
  logic        port8 = 1'b0;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;
  logic [15:0] bus_data = '0;
  logic        bus_cyc, bus_rd, busy, res_valid;
  logic [2:0]  bus_fc;
  logic [19:0] bus_addr;
  logic [1:0]  res_kind;
  logic [15:0] res_opcode;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bkpt_ack_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_num(sw_num),
    .hw_bkpt(hw_bkpt), .flush(flush), .port8(port8), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_data(bus_data), .bus_cyc(bus_cyc), .bus_rd(bus_rd),
    .bus_fc(bus_fc), .bus_addr(bus_addr), .busy(busy), .res_valid(res_valid),
    .res_kind(res_kind), .res_opcode(res_opcode)
  );

  typedef struct packed {
    logic        hw;
    logic [2:0]  num;
    logic        p8;
    logic        e1;
    logic        e2;
    logic [15:0] d1;
    logic [15:0] d2;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 16'h4E71, 16'h0000},
    '{1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 16'hDEAD, 16'h0000},
    '{1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 16'hA511, 16'h3C22},
    '{1'b0, 3'd6, 1'b1, 1'b0, 1'b1, 16'h7777, 16'h8888},
    '{1'b0, 3'd7, 1'b1, 1'b1, 1'b0, 16'h1111, 16'h2222},
    '{1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0000},
    '{1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 16'h5678, 16'h0000},
    '{1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 16'h9ABC, 16'h0000},
    '{1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 16'h00AA, 16'hFF55}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [19:0] exp_addr(input logic [2:0] num, input logic hw);
    return {16'h0000, num, hw, 1'b0};
  endfunction

  // result kind from the requirements: 0 replace, 1 continue, 2 illegal, 3 exception
  function automatic logic [1:0] exp_kind(input vec_t v);
    if (v.hw) return v.e1 ? 2'd3 : 2'd1;
    if (v.e1) return 2'd2;
    if (v.p8 && v.e2) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [15:0] exp_op(input vec_t v);
    if (exp_kind(v) != 2'd0) return 16'h0000;
    return v.p8 ? {v.d1[15:8], v.d2[15:8]} : v.d1;
  endfunction

  // drive one transfer termination, then sample at the next falling edge
  task automatic term(input logic ack, input logic err, input logic [15:0] d);
    bus_ack = ack; bus_err = err; bus_data = d;
    @(negedge clk);
    bus_ack = 1'b0; bus_err = 1'b0; bus_data = 16'hFFFF;
  endtask

  task automatic wait_cyc(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (bus_cyc) begin seen = 1; break; end
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit seen;
    logic [19:0] ea;
    ea = exp_addr(v.hw ? 3'd7 : v.num, v.hw);
    port8 = v.p8;
    if (v.hw) begin
      hw_bkpt = 1'b1;
      wait_cyc(4, seen);
      hw_bkpt = 1'b0;
      chk(seen, "R3", {31'd0, seen}, 32'd1);
    end else begin
      sw_req = 1'b1; sw_num = v.num;
      @(negedge clk);
      sw_req = 1'b0;
      chk(bus_cyc && bus_rd && busy, "R2", {29'd0, bus_cyc, bus_rd, busy}, 32'h7);
    end
    chk(bus_addr == ea && bus_fc == 3'b111, v.hw ? "R3" : "R2",
        {9'd0, bus_fc, bus_addr}, {9'd0, 3'b111, ea});
    term(!v.e1, v.e1, v.d1);
    if (!v.hw && v.p8 && !v.e1) begin
      chk(!res_valid && bus_cyc && bus_addr == ea, "R5",
          {10'd0, res_valid, bus_cyc, bus_addr}, {10'd0, 2'b01, ea});
      term(!v.e2, v.e2, v.d2);
    end
    chk(res_valid && res_kind == exp_kind(v), v.hw ? (v.e1 ? "R8" : "R7") :
        (v.e1 || (v.p8 && v.e2)) ? "R6" : (v.p8 ? "R5" : "R4"),
        {29'd0, res_valid, res_kind}, {29'd0, 1'b1, exp_kind(v)});
    chk(res_opcode == exp_op(v), (exp_kind(v) != 2'd0) ? "R12" : (v.p8 ? "R5" : "R4"),
        {16'd0, res_opcode}, {16'd0, exp_op(v)});
    chk(!bus_cyc, "R7", {31'd0, bus_cyc}, 32'd0);
    @(negedge clk);
    chk(!res_valid, "R4", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired (no requirement) actual=hang expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    bit seen;
    bus_data = 16'hFFFF;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!bus_cyc && !busy && !res_valid && bus_fc == 0 && bus_addr == 0, "R1",
        {8'd0, bus_cyc, busy, res_valid, bus_fc, bus_addr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_cyc && !busy && !res_valid, "R1",
        {29'd0, bus_cyc, busy, res_valid}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VT[i]);

    // R6 error and acknowledge together: error wins
    port8 = 1'b0; sw_req = 1'b1; sw_num = 3'd2;
    @(negedge clk);
    sw_req = 1'b0;
    term(1'b1, 1'b1, 16'hBEEF);
    chk(res_valid && res_kind == 2'd2, "R6", {30'd0, res_kind}, 32'd2);
    @(negedge clk);

    // R9 pin pulse then flush: request discarded
    hw_bkpt = 1'b1;
    @(negedge clk);
    hw_bkpt = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    wait_cyc(4, seen);
    chk(!seen, "R9", {31'd0, seen}, 32'd0);

    // R9 pin held across a flush: still served
    hw_bkpt = 1'b1;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    wait_cyc(4, seen);
    hw_bkpt = 1'b0;
    chk(seen && bus_addr == exp_addr(3'd7, 1'b1), "R9", {11'd0, seen, bus_addr},
        {11'd0, 1'b1, exp_addr(3'd7, 1'b1)});
    term(1'b1, 1'b0, 16'h0101);
    chk(res_valid && res_kind == 2'd1, "R7", {30'd0, res_kind}, 32'd1);
    @(negedge clk);

    // R10 pending pin and instruction request meet: software first
    hw_bkpt = 1'b1;
    @(negedge clk);
    hw_bkpt = 1'b0; sw_req = 1'b1; sw_num = 3'd4;
    @(negedge clk);
    sw_req = 1'b0;
    chk(bus_cyc && bus_addr == exp_addr(3'd4, 1'b0), "R10", {12'd0, bus_addr},
        {12'd0, exp_addr(3'd4, 1'b0)});
    term(1'b1, 1'b0, 16'h4AFC);
    chk(res_valid && res_kind == 2'd0 && res_opcode == 16'h4AFC, "R10",
        {16'd0, res_opcode}, 32'h4AFC);
    wait_cyc(3, seen);
    chk(seen && bus_addr == exp_addr(3'd7, 1'b1), "R10", {11'd0, seen, bus_addr},
        {11'd0, 1'b1, exp_addr(3'd7, 1'b1)});
    term(1'b0, 1'b1, 16'h0000);
    chk(res_valid && res_kind == 2'd3, "R8", {30'd0, res_kind}, 32'd3);
    @(negedge clk);

    // R11 request while busy is ignored, address held
    sw_req = 1'b1; sw_num = 3'd2;
    @(negedge clk);
    sw_num = 3'd6;
    @(negedge clk);
    sw_req = 1'b0;
    chk(bus_cyc && bus_addr == exp_addr(3'd2, 1'b0), "R11", {12'd0, bus_addr},
        {12'd0, exp_addr(3'd2, 1'b0)});
    term(1'b1, 1'b0, 16'h1357);
    chk(res_valid && res_opcode == 16'h1357, "R11", {16'd0, res_opcode}, 32'h1357);
    wait_cyc(3, seen);
    chk(!seen, "R11", {31'd0, seen}, 32'd0);

    finished = 1;
    summary();
    $finish;
  end
endmodule